// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a 16-bit CPU bus and the ROM and battery RAM of a game cartridge. The cartridge has more ROM and RAM than the CPU can address at once. CPU writes into the ROM address range do not reach the ROM. Instead they load a small set of control registers: a RAM gate, a 5-bit primary bank, a 2-bit secondary bank and a banking-mode flag. CPU reads are then translated into a physical ROM byte address or an external RAM byte address.

The translation is purely combinational. A bank change clocked in on one edge is therefore visible to the very next bus cycle. The ROM and RAM arrays live outside the block. The block only drives their addresses and strobes, and it multiplexes their data back onto the CPU read bus. Where no device answers, it returns the open-bus value 0xFF. Two static configuration inputs describe the cartridge fitted: the number of ROM banks, given as a power of two, and the RAM size.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, external RAM is gated off, the primary bank holds 1, the secondary bank holds 0 and the mode flag is 0.
- R2: A write anywhere in 0x0000–0x1FFF opens the RAM gate when data bits [3:0] equal 0xA, and closes it for any other value.
- R3: A write in 0x2000–0x3FFF loads data bits [4:0] into the primary bank. A value of zero in those bits loads 1 instead.
- R4: Bank numbers used for ROM translation are masked to the fitted ROM: with rom_size_i = n, only bank bits below n survive (2^n banks).
- R5: A write in 0x4000–0x5FFF loads data bits [1:0] into the secondary bank.
- R6: A write in 0x6000–0x7FFF loads data bit 0 into the mode flag.
- R7: A read in 0x4000–0x7FFF maps to ROM address ({secondary, primary} masked) × 0x4000 + (addr − 0x4000).
- R8: A read in 0x0000–0x3FFF maps to addr when the mode flag is 0. When it is 1, the read maps to ({secondary, 5'b0} masked) × 0x4000 + addr.
- R9: While the RAM gate is closed, reads in 0xA000–0xBFFF return 0xFF and both RAM strobes stay low, so a write there changes nothing.
- R10: The RAM size encoding is 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB. With 32 KiB and the mode flag set, the RAM address is secondary × 0x2000 + (addr − 0xA000). Otherwise it is (addr − 0xA000) modulo the RAM capacity, where the 32 KiB part in mode 0 uses the first 8 KiB.
- R11: Register writes take effect at the clock edge. A read in the cycle of a bank write still sees the old mapping, and a read in the next cycle sees the new one.
- R12: Read data is the ROM data for 0x0000–0x7FFF, the RAM data for an active RAM access, and 0xFF for 0x8000–0x9FFF and 0xC000–0xFFFF. rom_rd_o follows rd_i only for 0x0000–0x7FFF.
- R13: With RAM size 0 the RAM range behaves as gated off, even when the gate is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data (also RAM write data) |
| wr_i | input | 1 | CPU write strobe |
| rd_i | input | 1 | CPU read strobe |
| rom_size_i | input | 3 | log2 of the ROM bank count |
| ram_size_i | input | 2 | RAM size code (R10) |
| rom_rdata_i | input | 8 | Data from the ROM array |
| ram_rdata_i | input | 8 | Data from the RAM array |
| rom_addr_o | output | 21 | Physical ROM byte address |
| rom_rd_o | output | 1 | ROM read enable |
| ram_addr_o | output | 15 | Physical RAM byte address |
| ram_rd_o | output | 1 | RAM read enable |
| ram_we_o | output | 1 | RAM write enable |
| rdata_o | output | 8 | Read data back to the CPU |

## Verification
A bank-register write and an address translation can fall in the same cycle. This happens when the bench raises write and read together on an address inside the window that the write remaps, for example a secondary-bank write at 0x4000. In that cycle the bench expects the translated ROM address to reflect the old bank. In the following read cycle it expects the new bank. A behavioural model that changes its state only at clock edges judges every such cycle, in directed runs and in a long random run with the configuration changing as it goes.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam int unsigned CPU_AW    = 16;
  localparam int unsigned CPU_DW    = 8;
  localparam int unsigned BANK_LO_W = 5;
  localparam int unsigned BANK_HI_W = 2;
  localparam int unsigned PAGE_W    = 13;

  typedef enum logic [1:0] {
    RAM_NONE = 2'd0,
    RAM_2K   = 2'd1,
    RAM_8K   = 2'd2,
    RAM_32K  = 2'd3
  } ram_size_e;

  typedef enum logic [2:0] {
    AR_CTL_GATE,
    AR_CTL_LO,
    AR_CTL_HI,
    AR_CTL_MODE,
    AR_XRAM,
    AR_OPEN
  } area_e;

  // decode on the top three CPU address bits (8 KiB granules)
  function automatic area_e decode_area(input logic [2:0] top);
    case (top)
      3'd0:    return AR_CTL_GATE;
      3'd1:    return AR_CTL_LO;
      3'd2:    return AR_CTL_HI;
      3'd3:    return AR_CTL_MODE;
      3'd5:    return AR_XRAM;
      default: return AR_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int unsigned AW   = CPU_AW,
  parameter int unsigned DW   = CPU_DW,
  parameter int unsigned LO_W = BANK_LO_W,
  parameter int unsigned HI_W = BANK_HI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            ram_en_o,
  output logic [LO_W-1:0] lo_bank_o,
  output logic [HI_W-1:0] hi_bank_o,
  output logic            mode_o
);

  localparam logic [3:0] GATE_KEY = 4'hA;

  area_e           area;
  logic            we_gate, we_lo, we_hi, we_mode;
  logic [LO_W-1:0] lo_raw, lo_next;

  assign area    = decode_area(addr_i[AW-1 -: 3]);
  assign we_gate = wr_i && (area == AR_CTL_GATE);
  assign we_lo   = wr_i && (area == AR_CTL_LO);
  assign we_hi   = wr_i && (area == AR_CTL_HI);
  assign we_mode = wr_i && (area == AR_CTL_MODE);

  assign lo_raw  = wdata_i[LO_W-1:0];
  // bank 0 is never selectable in the primary register
  assign lo_next = (lo_raw == '0) ? LO_W'(1) : lo_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_o  <= 1'b0;
      lo_bank_o <= LO_W'(1);
      hi_bank_o <= '0;
      mode_o    <= 1'b0;
    end else begin
      if (we_gate) ram_en_o  <= (wdata_i[3:0] == GATE_KEY);
      if (we_lo)   lo_bank_o <= lo_next;
      if (we_hi)   hi_bank_o <= wdata_i[HI_W-1:0];
      if (we_mode) mode_o    <= wdata_i[0];
    end
  end

  AST_LO_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_bank_o != '0); // R3
  AST_LO_ZERO_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[AW-1 -: 3] == 3'd1 && wdata_i[LO_W-1:0] == '0) |=> lo_bank_o == LO_W'(1)); // R3
  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[AW-1 -: 3] == 3'd2) |=> hi_bank_o == $past(wdata_i[HI_W-1:0])); // R5
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[AW-1 -: 3] == 3'd3) |=> mode_o == $past(wdata_i[0])); // R6
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i[AW-1 -: 3] == 3'd0) |=> $stable(ram_en_o)); // R2

endmodule

// File: rtl/cart_rom_map.sv
module cart_rom_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned AW   = CPU_AW,
  parameter int unsigned LO_W = BANK_LO_W,
  parameter int unsigned HI_W = BANK_HI_W,
  localparam int unsigned WIN_W  = AW - 2,
  localparam int unsigned BANK_W = LO_W + HI_W,
  localparam int unsigned ROM_AW = BANK_W + WIN_W,
  localparam int unsigned SZ_W   = $clog2(BANK_W + 1)
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [SZ_W-1:0]   rom_size_i,
  input  logic [LO_W-1:0]   lo_bank_i,
  input  logic [HI_W-1:0]   hi_bank_i,
  input  logic              mode_i,
  output logic [ROM_AW-1:0] rom_addr_o
);

  logic [BANK_W-1:0] bank_mask, high_bank, zero_bank, sel_bank;

  for (genvar i = 0; i < BANK_W; i++) begin : g_mask
    assign bank_mask[i] = (rom_size_i > SZ_W'(i));
  end

  assign high_bank = {hi_bank_i, lo_bank_i} & bank_mask;
  assign zero_bank = {hi_bank_i, {LO_W{1'b0}}} & bank_mask;

  always_comb begin
    if (addr_i[AW-2])  sel_bank = high_bank;
    else if (mode_i)   sel_bank = zero_bank;
    else               sel_bank = '0;
  end

  assign rom_addr_o = {sel_bank, addr_i[WIN_W-1:0]};

endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned AW    = CPU_AW,
  parameter int unsigned HI_W  = BANK_HI_W,
  parameter int unsigned PG_W  = PAGE_W,
  localparam int unsigned SMALL_W = PG_W - 2,
  localparam int unsigned RAM_AW  = PG_W + HI_W
) (
  input  logic [AW-1:0]     addr_i,
  input  ram_size_e         ram_size_i,
  input  logic              ram_en_i,
  input  logic              mode_i,
  input  logic [HI_W-1:0]   hi_bank_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_rd_o,
  output logic              ram_we_o,
  output logic              ram_hit_o
);

  logic [PG_W-1:0] page_off;
  logic            in_area;

  assign page_off = addr_i[PG_W-1:0];
  assign in_area  = (decode_area(addr_i[AW-1 -: 3]) == AR_XRAM);

  always_comb begin
    case (ram_size_i)
      RAM_2K:  ram_addr_o = RAM_AW'(page_off[SMALL_W-1:0]);
      RAM_8K:  ram_addr_o = RAM_AW'(page_off);
      RAM_32K: ram_addr_o = mode_i ? {hi_bank_i, page_off} : RAM_AW'(page_off);
      default: ram_addr_o = '0;
    endcase
  end

  assign ram_hit_o = in_area && ram_en_i && (ram_size_i != RAM_NONE);
  assign ram_rd_o  = rd_i && ram_hit_o;
  assign ram_we_o  = wr_i && ram_hit_o;

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int unsigned AW   = CPU_AW,
  parameter int unsigned DW   = CPU_DW,
  parameter int unsigned LO_W = BANK_LO_W,
  parameter int unsigned HI_W = BANK_HI_W,
  parameter int unsigned PG_W = PAGE_W,
  localparam int unsigned BANK_W = LO_W + HI_W,
  localparam int unsigned ROM_AW = BANK_W + AW - 2,
  localparam int unsigned RAM_AW = PG_W + HI_W,
  localparam int unsigned SZ_W   = $clog2(BANK_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [SZ_W-1:0]   rom_size_i,
  input  logic [1:0]        ram_size_i,
  input  logic [DW-1:0]     rom_rdata_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_rd_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_rd_o,
  output logic              ram_we_o,
  output logic [DW-1:0]     rdata_o
);

  localparam logic [DW-1:0] OPEN_BUS = '1;

  logic            ram_en, mode, ram_hit, rom_area;
  logic [LO_W-1:0] lo_bank;
  logic [HI_W-1:0] hi_bank;
  ram_size_e       ram_size;

  assign ram_size = ram_size_e'(ram_size_i);
  assign rom_area = ~addr_i[AW-1];

  cart_bank_regs #(.AW(AW), .DW(DW), .LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ram_en_o  (ram_en),
    .lo_bank_o (lo_bank),
    .hi_bank_o (hi_bank),
    .mode_o    (mode)
  );

  cart_rom_map #(.AW(AW), .LO_W(LO_W), .HI_W(HI_W)) u_rom (
    .addr_i     (addr_i),
    .rom_size_i (rom_size_i),
    .lo_bank_i  (lo_bank),
    .hi_bank_i  (hi_bank),
    .mode_i     (mode),
    .rom_addr_o (rom_addr_o)
  );

  cart_ram_map #(.AW(AW), .HI_W(HI_W), .PG_W(PG_W)) u_ram (
    .addr_i     (addr_i),
    .ram_size_i (ram_size),
    .ram_en_i   (ram_en),
    .mode_i     (mode),
    .hi_bank_i  (hi_bank),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .ram_addr_o (ram_addr_o),
    .ram_rd_o   (ram_rd_o),
    .ram_we_o   (ram_we_o),
    .ram_hit_o  (ram_hit)
  );

  assign rom_rd_o = rd_i && rom_area;

  always_comb begin
    if (rom_area)     rdata_o = rom_rdata_i;
    else if (ram_hit) rdata_o = ram_rdata_i;
    else              rdata_o = OPEN_BUS;
  end

  AST_LOW_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode && addr_i[AW-1 -: 2] == 2'b00) |-> rom_addr_o == ROM_AW'(addr_i)); // R8
  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_en && addr_i[AW-1 -: 3] == 3'd5) |-> (rdata_o == OPEN_BUS && !ram_we_o && !ram_rd_o)); // R9
  AST_NO_RAM_PART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_size_i == 2'd0) |-> (!ram_we_o && !ram_rd_o)); // R13
  AST_OPEN_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1 -: 3] == 3'd4 || addr_i[AW-1 -: 2] == 2'b11) |-> (rdata_o == OPEN_BUS && !rom_rd_o)); // R12
  AST_SMALL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_size_i == 2'd1 && ram_rd_o) |-> ram_addr_o < RAM_AW'(2048)); // R10

endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  rom_size = 3'd7;
  logic [1:0]  ram_size = 2'd3;
  logic [7:0]  rom_rdata, ram_rdata, rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_rd, ram_rd, ram_we;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  int m_en = 0, m_lo = 1, m_hi = 0, m_mode = 0;

  always #4 clk = ~clk;

  assign rom_rdata = 8'h5A ^ addr[7:0];
  assign ram_rdata = 8'hC3 ^ addr[7:0];

  cart_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rom_size_i(rom_size), .ram_size_i(ram_size),
    .rom_rdata_i(rom_rdata), .ram_rdata_i(ram_rdata),
    .rom_addr_o(rom_addr), .rom_rd_o(rom_rd), .ram_addr_o(ram_addr),
    .ram_rd_o(ram_rd), .ram_we_o(ram_we), .rdata_o(rdata)
  );

  // reference state, changes only at clock edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_lo = 1; m_hi = 0; m_mode = 0;
    end else if (wr && addr < 16'h8000) begin
      if (addr < 16'h2000)      m_en = ((wdata & 8'h0F) == 8'h0A) ? 1 : 0;
      else if (addr < 16'h4000) begin m_lo = wdata % 32; if (m_lo == 0) m_lo = 1; end
      else if (addr < 16'h6000) m_hi = wdata % 4;
      else                      m_mode = wdata % 2;
    end
  end

  function automatic longint exp_rom(int a);
    int msk = (1 << rom_size) - 1;
    int b;
    if (a < 'h4000) begin
      b = m_mode ? ((m_hi * 32) & msk) : 0;
      return longint'(b) * 'h4000 + a;
    end
    b = (m_hi * 32 + m_lo) & msk;
    return longint'(b) * 'h4000 + (a - 'h4000);
  endfunction

  function automatic bit exp_hit(int a);
    return (a >= 'hA000 && a < 'hC000 && m_en != 0 && ram_size != 0);
  endfunction

  function automatic longint exp_ram(int a);
    int off = a - 'hA000;
    case (ram_size)
      2'd1:    return off % 2048;
      2'd2:    return off % 8192;
      2'd3:    return m_mode ? (m_hi * 8192 + off) : off;
      default: return 0;
    endcase
  endfunction

  function automatic longint exp_rdata(int a);
    if (a < 'h8000) return (8'h5A ^ a[7:0]);
    if (exp_hit(a)) return (8'hC3 ^ a[7:0]);
    return 'hFF;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      #2;
      if (int'(addr) < 'h8000)
        chk(addr < 16'h4000 ? "R8 low window" : "R7 high window", rom_addr, exp_rom(addr));
      chk("R12 rom strobe", rom_rd, longint'(rd && addr < 16'h8000));
      chk("R12 read data", rdata, exp_rdata(addr));
      chk("R9 ram strobes", {ram_rd, ram_we}, {rd && exp_hit(addr), wr && exp_hit(addr)});
      if (exp_hit(addr)) chk("R10 ram address", ram_addr, exp_ram(addr));
    end
  end

  task automatic cyc(logic [15:0] a, logic [7:0] d, logic w, logic r);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r;
    #3;
  endtask

  task automatic wreg(logic [15:0] a, logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0);
  endtask

  task automatic rdb(logic [15:0] a);
    cyc(a, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1 reset state
    rdb(16'h4123); chk("R1 reset primary bank", rom_addr, 21'h04123);
    rdb(16'hA000); chk("R1 reset ram gate", rdata, 8'hFF);
    rdb(16'h0123); chk("R1 reset mode", rom_addr, 21'h00123);

    // R3 primary bank
    wreg(16'h2000, 8'h00); rdb(16'h4000); chk("R3 zero loads one", rom_addr, 21'h04000);
    wreg(16'h2100, 8'h13); rdb(16'h4001); chk("R3 bank 0x13", rom_addr, 21'h4C001);
    wreg(16'h3FFF, 8'hE0); rdb(16'h7FFF); chk("R3 low five zero", rom_addr, 21'h07FFF);
    wreg(16'h2000, 8'h13);

    // R5 secondary bank, R4 masking
    wreg(16'h5000, 8'hFE); rdb(16'h4000); chk("R5 secondary bank", rom_addr, 21'h14C000);
    rom_size = 3'd4; rdb(16'h4000); chk("R4 mask 16 banks", rom_addr, 21'h0C000);
    rom_size = 3'd6; rdb(16'h4000); chk("R4 mask 64 banks", rom_addr, 21'h4C000);
    rom_size = 3'd7;

    // R6 mode, R8 low window
    wreg(16'h6000, 8'h01); rdb(16'h0010); chk("R8 mode1 low window", rom_addr, 21'h100010);
    rom_size = 3'd5; rdb(16'h0010); chk("R4 zero bank masked", rom_addr, 21'h00010);
    rom_size = 3'd7;
    wreg(16'h7FFF, 8'hFE); rdb(16'h0010); chk("R6 mode cleared", rom_addr, 21'h00010);

    // R2 ram gate
    wreg(16'h1000, 8'h3A); rdb(16'hA005);
    chk("R2 gate open data", rdata, 8'hC6); chk("R2 gate open strobe", ram_rd, 1);
    wreg(16'h0000, 8'h0B); rdb(16'hA005); chk("R2 gate closed", rdata, 8'hFF);
    wreg(16'h1FFF, 8'hFA);

    // R10 ram address
    rdb(16'hA123); chk("R10 32K mode0", ram_addr, 15'h0123);
    wreg(16'h6000, 8'h01); rdb(16'hA123); chk("R10 32K mode1", ram_addr, 15'h4123);
    ram_size = 2'd1; rdb(16'hB9FF); chk("R10 2K wrap", ram_addr, 15'h01FF);
    ram_size = 2'd2; rdb(16'hB9FF); chk("R10 8K", ram_addr, 15'h19FF);
    ram_size = 2'd3; wreg(16'h6000, 8'h00);
    cyc(16'hA010, 8'h55, 1'b1, 1'b0); chk("R2 open gate write", ram_we, 1);

    // R9 closed gate ignores access
    wreg(16'h0000, 8'h00);
    cyc(16'hA010, 8'h55, 1'b1, 1'b0); chk("R9 write ignored", ram_we, 0);
    rdb(16'hA010); chk("R9 open bus", rdata, 8'hFF); chk("R9 no read strobe", ram_rd, 0);
    wreg(16'h0000, 8'h0A);

    // R11 write and read in the same cycle
    cyc(16'h4000, 8'h01, 1'b1, 1'b1); chk("R11 old map during write", rom_addr, 21'h14C000);
    rdb(16'h4000); chk("R11 new map next cycle", rom_addr, 21'h0CC000);

    // R12 data mux
    rdb(16'h9000); chk("R12 hole 0x9000", rdata, 8'hFF);
    rdb(16'hC000); chk("R12 hole 0xC000", rdata, 8'hFF);
    rdb(16'hFFFF); chk("R12 hole 0xFFFF", rdata, 8'hFF); chk("R12 no rom strobe", rom_rd, 0);
    rdb(16'h2345); chk("R12 rom data", rdata, 8'h1F); chk("R12 rom strobe", rom_rd, 1);

    // R13 no ram fitted
    ram_size = 2'd0; rdb(16'hA000);
    chk("R13 no ram data", rdata, 8'hFF); chk("R13 no ram strobe", ram_rd, 0);
    ram_size = 2'd3;

    // random traffic, configuration varies
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic w;
      if (i % 150 == 0) begin
        rom_size = 3'($urandom % 8);
        ram_size = 2'($urandom % 4);
      end
      a = 16'($urandom);
      w = ($urandom % 3 == 0);
      cyc(a, 8'($urandom), w, !w || ($urandom % 2 == 1));
    end
    cyc(16'h0000, 8'h00, 1'b0, 1'b0);
    finish_run();
  end

endmodule